// File: doc/BRIEF.md
# Receive Descriptor Completion Interrupt Generator

This block follows a receive DMA engine as it fills a linked chain of host-memory buffer descriptors, one frame at a time. From the engine's events (a byte stored, the current descriptor finished, a receiver reset command, a resume pulse) and the control bits of the descriptor in use (frame-end, hold, buffer size in bytes), it decides when a frame-indication flag (FI) and an error flag (ERR) must be reported. It emits them together as one interrupt vector.

A frame is reported when the engine leaves the descriptor in which the frame ended, when it stops on a hold descriptor, or when a reset command cuts a frame short. The error flag marks frames that could not be stored whole: the hold buffer ran out of room, a hold descriptor was finished before the frame ended, or the frame was aborted. After any hold the block ignores chain activity until software pulses resume.

Vectors are queued in a small FIFO and handed out with a ready/valid handshake. A sticky overflow flag records that a vector was lost because the queue was full.

Top module: `rxirq_gen`

## Requirements
- R1: When `desc_next` is pulsed on a descriptor with `cur_fe`=1 and `cur_hold`=0, one vector with FI=1, ERR=0 is produced, and the frame is closed.
- R2: When `desc_next` is pulsed with `cur_fe`=0 and `cur_hold`=0, no vector is produced, the frame continues, and the byte count of the current buffer restarts at zero.
- R3: When `desc_next` is pulsed on a descriptor with `cur_hold`=1 and `cur_fe`=1, one vector with FI=1, ERR=0 is produced and the block enters the held state.
- R4: A frame that does not fit its hold descriptor yields FI=1, ERR=1 and enters the held state. This happens on a `byte_wr` that arrives after `cur_len` bytes are already in a buffer with `cur_hold`=1, or on a `desc_next` with `cur_hold`=1 and `cur_fe`=0.
- R5: `rx_rst_cmd` while a frame is in progress (at least one byte since the last frame close) yields FI=1, ERR=1 and closes the frame. With no frame in progress, it yields no vector.
- R6: In the held state `byte_wr` and `desc_next` have no effect until `resume` is pulsed. After the resume pulse, normal tracking continues.
- R7: When events coincide in one cycle, `rx_rst_cmd` takes precedence over `desc_next`, which takes precedence over `byte_wr`. Only the winning event is acted on.
- R8: A vector with both flags clear is never presented. `vec_valid` is high only with `vec_fi` or `vec_err` high.
- R9: Up to DEPTH (default 4) vectors are queued in order. While `vec_ready` is low, the presented vector stays unchanged.
- R10: A vector produced while DEPTH vectors are queued and none is being taken is dropped, and `vec_ovf` goes high. It stays high until `rst`.
- R11: After `rst`, `vec_valid` and `vec_ovf` are low, no frame is in progress and the block is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_wr | input | 1 | One frame byte stored into the current buffer |
| desc_next | input | 1 | Engine has finished the current descriptor |
| rx_rst_cmd | input | 1 | Receiver reset command |
| resume | input | 1 | Leave the held state |
| cur_fe | input | 1 | Current descriptor: frame ends here |
| cur_hold | input | 1 | Current descriptor: hold condition |
| cur_len | input | LEN_W | Current descriptor buffer size in bytes |
| vec_ready | input | 1 | Consumer accepts the presented vector |
| vec_valid | output | 1 | A vector is presented |
| vec_fi | output | 1 | Frame-indication flag of the presented vector |
| vec_err | output | 1 | Error flag of the presented vector |
| vec_ovf | output | 1 | Sticky: a vector was dropped |

## Verification
The hardest case to reach is the dropped vector. It needs DEPTH vectors already waiting, the consumer stalled, and a new interrupt-producing event in the same cycle. The stimulus gets there by holding `vec_ready` low and producing five aborted frames in a row, each one a single byte followed by a reset command. The scoreboard expects only the first four, then checks the sticky flag across the drain. The held state is reached the same way, on purpose: through a hold descriptor that completes a frame. Frame-end branches and byte writes are then issued, and they must produce nothing.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
  typedef struct packed {
    logic fi;
    logic err;
  } irq_vec_t;
  localparam int VEC_W = $bits(irq_vec_t);
endpackage

// File: rtl/rxirq_tracker.sv
module rxirq_tracker
  import rxirq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_wr,
  input  logic             desc_next,
  input  logic             rx_rst_cmd,
  input  logic             resume,
  input  logic             cur_fe,
  input  logic             cur_hold,
  input  logic [LEN_W-1:0] cur_len,
  output logic             vec_vld,
  output irq_vec_t         vec,
  output logic             held_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             in_frame_q, in_frame_d;
  logic             held_q, held_d;
  irq_vec_t         v_d;

  always_comb begin
    cnt_d      = cnt_q;
    in_frame_d = in_frame_q;
    held_d     = held_q;
    v_d        = '0;
    if (rx_rst_cmd) begin
      if (in_frame_q) begin
        v_d.fi  = 1'b1;
        v_d.err = 1'b1;
      end
      in_frame_d = 1'b0;
      cnt_d      = '0;
    end else if (!held_q && desc_next) begin
      cnt_d = '0;
      if (cur_hold) begin
        held_d     = 1'b1;
        v_d.fi     = 1'b1;
        v_d.err    = !cur_fe;
        in_frame_d = 1'b0;
      end else if (cur_fe) begin
        v_d.fi     = 1'b1;
        in_frame_d = 1'b0;
      end
    end else if (!held_q && byte_wr) begin
      in_frame_d = 1'b1;
      if (cnt_q >= cur_len) begin
        if (cur_hold) begin
          v_d.fi     = 1'b1;
          v_d.err    = 1'b1;
          held_d     = 1'b1;
          in_frame_d = 1'b0;
          cnt_d      = '0;
        end
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (resume && held_q) held_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      held_q     <= 1'b0;
      vec_vld    <= 1'b0;
      vec        <= '0;
    end else begin
      cnt_q      <= cnt_d;
      in_frame_q <= in_frame_d;
      held_q     <= held_d;
      vec_vld    <= v_d.fi | v_d.err;
      vec        <= v_d;
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/rxirq_fifo.sv
module rxirq_fifo #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             pop, full, accept;

  assign full   = (cnt == FULL);
  assign pop    = out_valid && pop_ready;
  assign accept = push && (!full || pop);

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (accept) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)    rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      if (accept && !pop)      cnt <= cnt + 1'b1;
      else if (!accept && pop) cnt <= cnt - 1'b1;
      if (push && !accept) ovf <= 1'b1;
    end
  end

  assign out_valid = (cnt != '0);
  assign out_data  = mem[rptr];
endmodule

// File: rtl/rxirq_gen.sv
module rxirq_gen
  import rxirq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_wr,
  input  logic             desc_next,
  input  logic             rx_rst_cmd,
  input  logic             resume,
  input  logic             cur_fe,
  input  logic             cur_hold,
  input  logic [LEN_W-1:0] cur_len,
  input  logic             vec_ready,
  output logic             vec_valid,
  output logic             vec_fi,
  output logic             vec_err,
  output logic             vec_ovf
);
  logic             trk_vld;
  irq_vec_t         trk_vec;
  logic             trk_held;
  logic [VEC_W-1:0] q_data;
  irq_vec_t         q_vec;

  rxirq_tracker #(.LEN_W(LEN_W)) u_trk (
    .clk(clk), .rst(rst), .byte_wr(byte_wr), .desc_next(desc_next),
    .rx_rst_cmd(rx_rst_cmd), .resume(resume), .cur_fe(cur_fe),
    .cur_hold(cur_hold), .cur_len(cur_len),
    .vec_vld(trk_vld), .vec(trk_vec), .held_o(trk_held)
  );

  rxirq_fifo #(.WIDTH(VEC_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(trk_vld), .push_data(trk_vec),
    .pop_ready(vec_ready), .out_valid(vec_valid), .out_data(q_data),
    .ovf(vec_ovf)
  );

  assign q_vec   = irq_vec_t'(q_data);
  assign vec_fi  = q_vec.fi;
  assign vec_err = q_vec.err;
endmodule

// File: rtl/rxirq_gen_chk.sv
module rxirq_gen_chk (
  input logic clk,
  input logic rst,
  input logic rx_rst_cmd,
  input logic vec_ready,
  input logic vec_valid,
  input logic vec_fi,
  input logic vec_err,
  input logic vec_ovf,
  input logic held,
  input logic trk_vld
);
  assert_flag_present_R8: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_fi || vec_err));

  assert_err_has_fi_R4: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_err) |-> vec_fi);

  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_fi) && $stable(vec_err)));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    vec_ovf |=> vec_ovf);

  assert_held_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (held && !rx_rst_cmd) |=> !trk_vld);

  assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!vec_valid && !vec_ovf));
endmodule

bind rxirq_gen rxirq_gen_chk u_chk (
  .clk(clk), .rst(rst), .rx_rst_cmd(rx_rst_cmd), .vec_ready(vec_ready),
  .vec_valid(vec_valid), .vec_fi(vec_fi), .vec_err(vec_err),
  .vec_ovf(vec_ovf), .held(trk_held), .trk_vld(trk_vld)
);

// File: tb/rxirq_gen_bench.sv
module rxirq_gen_bench;
  localparam int CLK_NS = 10;
  localparam int LEN_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_wr = 0, desc_next = 0, rx_rst_cmd = 0, resume = 0;
  logic cur_fe = 0, cur_hold = 0;
  logic [LEN_W-1:0] cur_len = 8'd8;
  logic vec_ready = 1'b1;
  logic vec_valid, vec_fi, vec_err, vec_ovf;

  int checks = 0;
  int fails  = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  string      cur_tag = "R11";

  always #(CLK_NS/2) clk = ~clk;

  rxirq_gen #(.LEN_W(LEN_W), .DEPTH(4)) u_rxirq_gen (
    .clk(clk), .rst(rst), .byte_wr(byte_wr), .desc_next(desc_next),
    .rx_rst_cmd(rx_rst_cmd), .resume(resume), .cur_fe(cur_fe),
    .cur_hold(cur_hold), .cur_len(cur_len), .vec_ready(vec_ready),
    .vec_valid(vec_valid), .vec_fi(vec_fi), .vec_err(vec_err), .vec_ovf(vec_ovf)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic desc(input logic fe, input logic hold, input int len);
    cur_fe = fe; cur_hold = hold; cur_len = LEN_W'(len);
  endtask

  task automatic ev(input logic bw, input logic dn, input logic rc, input logic rs);
    byte_wr = bw; desc_next = dn; rx_rst_cmd = rc; resume = rs;
    step();
    byte_wr = 0; desc_next = 0; rx_rst_cmd = 0; resume = 0;
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) ev(1, 0, 0, 0);
  endtask

  task automatic expect_vec(input logic fi, input logic err, input string tag);
    exp_q.push_back({fi, err});
    tag_q.push_back(tag);
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input string tag);
    repeat (8) step();
    check(exp_q.size() == 0, {tag, " pending expected vectors"}, exp_q.size(), 0);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && vec_valid && vec_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, {cur_tag, " unexpected vector"}, {vec_fi, vec_err}, 0);
        end else begin
          logic [1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({vec_fi, vec_err} == e, {t, " vector {fi,err}"}, {vec_fi, vec_err}, e);
          check(vec_fi || vec_err, "R8 empty vector", {vec_fi, vec_err}, 1);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    check(!vec_valid, "R11 vec_valid after reset", vec_valid, 0);
    check(!vec_ovf, "R11 vec_ovf after reset", vec_ovf, 0);

    // R1: frame ends in a plain descriptor
    cur_tag = "R1";
    desc(0, 0, 8); bytes(2);
    desc(1, 0, 8); expect_vec(1, 0, "R1"); ev(0, 1, 0, 0);
    settle("R1");

    // R2: continue into next buffer; count restarts, so 3 more bytes fit
    cur_tag = "R2";
    desc(0, 0, 3); bytes(3); ev(0, 1, 0, 0);
    settle("R2");
    // R3: hold descriptor with frame end
    cur_tag = "R3";
    desc(0, 1, 3); bytes(3);
    desc(1, 1, 3); expect_vec(1, 0, "R3/R2"); ev(0, 1, 0, 0);
    settle("R3");

    // R6: held, bytes and branches ignored; reset cmd finds no frame
    cur_tag = "R6";
    desc(1, 0, 8); bytes(2); ev(0, 1, 0, 0); ev(0, 0, 1, 0);
    settle("R6 held ignores");
    ev(0, 0, 0, 1);
    bytes(1);
    expect_vec(1, 1, "R6 after resume"); ev(0, 0, 1, 0);
    settle("R6 resume");

    // R5: reset command with no frame in progress
    cur_tag = "R5";
    ev(0, 0, 1, 0);
    settle("R5 idle reset cmd");
    desc(0, 0, 8); bytes(4);
    expect_vec(1, 1, "R5 abort"); ev(0, 0, 1, 0);
    settle("R5 abort");

    // R4: overflow of hold buffer
    cur_tag = "R4";
    desc(0, 1, 2); bytes(2);
    settle("R4 exact fit no vector");
    expect_vec(1, 1, "R4 overflow"); bytes(1);
    settle("R4 overflow");
    ev(0, 0, 0, 1);
    desc(0, 1, 8); bytes(1);
    expect_vec(1, 1, "R4 hold without fe"); ev(0, 1, 0, 0);
    settle("R4 hold without fe");
    ev(0, 0, 0, 1);

    // R7: reset cmd wins over coincident frame-end branch
    cur_tag = "R7";
    desc(1, 0, 8); bytes(1);
    expect_vec(1, 1, "R7 priority"); ev(1, 1, 1, 0);
    settle("R7");

    // R9: ordering and stall stability
    cur_tag = "R9";
    vec_ready = 0;
    desc(1, 0, 8); ev(0, 1, 0, 0);
    bytes(1); ev(0, 0, 1, 0);
    ev(0, 1, 0, 0);
    repeat (3) step();
    check(vec_valid && vec_fi && !vec_err, "R9 stalled head", {vec_valid, vec_fi, vec_err}, 3'b110);
    repeat (3) step();
    check(vec_valid && vec_fi && !vec_err, "R9 stalled head stable", {vec_valid, vec_fi, vec_err}, 3'b110);
    expect_vec(1, 0, "R9 first"); expect_vec(1, 1, "R9 second"); expect_vec(1, 0, "R9 third");
    vec_ready = 1;
    settle("R9");

    // R10: overflow drops the fifth vector
    cur_tag = "R10";
    vec_ready = 0;
    desc(0, 0, 8);
    for (int k = 0; k < 5; k++) begin
      bytes(1); ev(0, 0, 1, 0);
    end
    repeat (3) step();
    check(vec_ovf, "R10 overflow flag", vec_ovf, 1);
    for (int k = 0; k < 4; k++) expect_vec(1, 1, "R10 kept");
    vec_ready = 1;
    settle("R10");
    check(vec_ovf, "R10 flag sticky after drain", vec_ovf, 1);
    rst = 1; step(); rst = 0; step();
    check(!vec_ovf && !vec_valid, "R11 flag cleared by rst", {vec_ovf, vec_valid}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule